// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block translates a virtual address into a physical address for a segmented memory controller. Sixteen 32-bit segment descriptors are held internally and loaded through a single-word write port. Bits [19:16] of the virtual address select a descriptor, and bits [15:0] are the byte offset inside that segment. Each descriptor packs four things into one word:

- a base origin,
- a length counted in 256-byte units,
- a present flag,
- two write-protect flags.

Each translation returns a 4-bit condition code in processor style: 8 means the address is illegal, 2 means the address is legal but the segment is write-protected, and 0 means the address is legal and writable. A fault flag combines the code with the access type. A request strobe starts a translation, and the result is registered and appears one clock later with a valid flag. The result stays on the outputs until the next request.

Top module: `seg_reloc_unit`

## Requirements
- R1: The descriptor index is vaddr_i[19:16] and the offset is vaddr_i[15:0]. Bits [31:20] of vaddr_i have no effect on the result.
- R2: If bit 4 of the selected descriptor (the present flag) is 0, the result is illegal.
- R3: Descriptor bits [31:20] hold L. An offset greater than or equal to (L+1)*256 is illegal. An offset below that limit passes the length check.
- R4: For a legal address whose descriptor has bit 5 or bit 6 set, cc_o is 2.
- R5: For a legal address with bits 5 and 6 both clear, cc_o is 0. In every legal case, paddr_o equals (descriptor AND 0x000FFF00) plus the offset.
- R6: For an illegal address, cc_o is exactly 8 whatever the protect flags are, paddr_o is 0, and fault_o is 1 for both reads and writes.
- R7: For a legal address, fault_o is 1 only when req_write_i was 1 and the segment is write-protected. A read of a protected segment does not fault.
- R8: valid_o is 1 in the cycle after each clock edge that samples req_i high, and 0 otherwise. A cycle without a request leaves paddr_o, cc_o and fault_o unchanged.
- R9: After reset all descriptors are 0, so every segment is absent, and valid_o, paddr_o, cc_o and fault_o are 0.
- R10: A descriptor write takes effect at the clock edge that samples it. A translation sampled at that same edge still uses the previous descriptor value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor write enable |
| desc_idx_i | input | 4 | Index of the descriptor to write |
| desc_wdata_i | input | 32 | Descriptor write data |
| req_i | input | 1 | Translation request strobe |
| req_write_i | input | 1 | Access type of the request: 1 for write, 0 for read |
| vaddr_i | input | 32 | Virtual address to translate |
| paddr_o | output | 32 | Relocated physical address, 0 when illegal |
| cc_o | output | 4 | Condition code: 8 illegal, 2 protected, 0 writable |
| fault_o | output | 1 | Illegal access, or a write to a protected segment |
| valid_o | output | 1 | The result registers hold a new translation |

## Verification
A wrong descriptor bit shows up at the ports on the next request that selects that segment, one clock after the strobe. It appears as a wrong code, a shifted physical address, or a missing or spurious fault. A fault in the output stage is visible sooner: a lost or stretched valid_o, or outputs that drift during idle cycles, shows up in the very next cycle. For that reason the bench compares every output on every clock against a model that holds its own copy of the sixteen descriptors. It also pins the same-edge write-then-translate ordering to the old descriptor value.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  localparam logic [3:0] CC_OK      = 4'h0;
  localparam logic [3:0] CC_WPROT   = 4'h2;
  localparam logic [3:0] CC_ILLEGAL = 4'h8;
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file #(
  parameter int unsigned SEG_CNT = 16,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(SEG_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] desc_q [SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_desc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    desc_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))           desc_q[g] <= wdata_i;
    end
  end

  assign rdata_o = desc_q[ridx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_reloc_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OFF_BITS  = 16,
  parameter int unsigned SEG_BITS  = 4,
  parameter int unsigned UNIT_BITS = 8,
  parameter int unsigned PRES_BIT  = 4,
  parameter int unsigned WP_LO     = 5,
  parameter int unsigned WP_HI     = 6,
  localparam int unsigned LEN_LSB  = OFF_BITS + SEG_BITS,
  localparam int unsigned LEN_W    = DATA_W - LEN_LSB,
  localparam int unsigned LIM_W    = LEN_W + 1 + UNIT_BITS
) (
  input  logic [DATA_W-1:0]   desc_i,
  input  logic [OFF_BITS-1:0] offset_i,
  input  logic                is_write_i,
  output logic [DATA_W-1:0]   paddr_o,
  output logic [3:0]          cc_o,
  output logic                fault_o
);
  logic [LIM_W-1:0]  limit, off_ext;
  logic [DATA_W-1:0] origin;
  logic              present, in_range, wprot, illegal;

  always_comb begin
    limit    = {({1'b0, desc_i[DATA_W-1 -: LEN_W]} + {{LEN_W{1'b0}}, 1'b1}), {UNIT_BITS{1'b0}}};
    off_ext  = {{(LIM_W-OFF_BITS){1'b0}}, offset_i};
    present  = desc_i[PRES_BIT];
    in_range = off_ext < limit;
    wprot    = |desc_i[WP_HI:WP_LO];
    illegal  = !present || !in_range;
    origin   = {{(DATA_W-LEN_LSB){1'b0}}, desc_i[LEN_LSB-1:UNIT_BITS], {UNIT_BITS{1'b0}}};
    if (illegal) begin
      paddr_o = '0;
      cc_o    = CC_ILLEGAL;   // protection not reported
      fault_o = 1'b1;
    end else begin
      paddr_o = origin + {{(DATA_W-OFF_BITS){1'b0}}, offset_i};
      cc_o    = wprot ? CC_WPROT : CC_OK;
      fault_o = wprot && is_write_i;
    end
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] paddr_i,
  input  logic [3:0]        cc_i,
  input  logic              fault_i,
  output logic [DATA_W-1:0] paddr_o,
  output logic [3:0]        cc_o,
  output logic              fault_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o <= '0;
      cc_o    <= '0;
      fault_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        paddr_o <= paddr_i;
        cc_o    <= cc_i;
        fault_o <= fault_i;
      end
    end
  end
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFF_BITS = 16,
  parameter int unsigned SEG_BITS = 4,
  localparam int unsigned SEG_CNT = 1 << SEG_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                desc_we_i,
  input  logic [SEG_BITS-1:0] desc_idx_i,
  input  logic [DATA_W-1:0]   desc_wdata_i,
  input  logic                req_i,
  input  logic                req_write_i,
  input  logic [DATA_W-1:0]   vaddr_i,
  output logic [DATA_W-1:0]   paddr_o,
  output logic [3:0]          cc_o,
  output logic                fault_o,
  output logic                valid_o
);
  logic [DATA_W-1:0] desc_rd, paddr_c;
  logic [3:0]        cc_c;
  logic              fault_c;

  seg_desc_file #(.SEG_CNT(SEG_CNT), .DATA_W(DATA_W)) i_desc (
    .clk_i, .rst_ni,
    .we_i    (desc_we_i),
    .widx_i  (desc_idx_i),
    .wdata_i (desc_wdata_i),
    .ridx_i  (vaddr_i[OFF_BITS +: SEG_BITS]),
    .rdata_o (desc_rd)
  );

  seg_check #(.DATA_W(DATA_W), .OFF_BITS(OFF_BITS), .SEG_BITS(SEG_BITS)) i_check (
    .desc_i     (desc_rd),
    .offset_i   (vaddr_i[OFF_BITS-1:0]),
    .is_write_i (req_write_i),
    .paddr_o    (paddr_c),
    .cc_o       (cc_c),
    .fault_o    (fault_c)
  );

  seg_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk_i, .rst_ni,
    .load_i  (req_i),
    .paddr_i (paddr_c),
    .cc_i    (cc_c),
    .fault_i (fault_c),
    .paddr_o, .cc_o, .fault_o, .valid_o
  );
endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              req_write_i,
  input logic [DATA_W-1:0] paddr_o,
  input logic [3:0]        cc_o,
  input logic              fault_o,
  input logic              valid_o
);
  p_valid_follows_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_no_valid_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  p_hold_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(paddr_o) && $stable(cc_o) && $stable(fault_o)));
  p_cc_encoding_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cc_o == 4'h0 || cc_o == 4'h2 || cc_o == 4'h8));
  p_illegal_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cc_o == 4'h8) |-> (fault_o && paddr_o == '0));
  p_writable_no_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !req_write_i) |=> (cc_o == 4'h8 || !fault_o));
  p_protected_write_faults_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cc_o == 4'h2) |-> (fault_o == $past(req_write_i)));
endmodule

bind seg_reloc_unit seg_reloc_chk #(.DATA_W(DATA_W)) i_seg_reloc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .req_write_i (req_write_i),
  .paddr_o     (paddr_o),
  .cc_o        (cc_o),
  .fault_o     (fault_o),
  .valid_o     (valid_o)
);

// File: tb/test_seg_reloc_unit.sv
module test_seg_reloc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        desc_we_i = 1'b0;
  logic [3:0]  desc_idx_i = '0;
  logic [31:0] desc_wdata_i = '0;
  logic        req_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [31:0] paddr_o;
  logic [3:0]  cc_o;
  logic        fault_o, valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // model state
  logic [31:0] m_desc [16];
  logic [31:0] e_paddr = '0;
  logic [3:0]  e_cc    = '0;
  logic        e_fault = 1'b0;
  logic        e_valid = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_reloc_unit i_seg_reloc_unit (.*);

  task automatic model_xlate(input logic [31:0] d, input logic [31:0] va, input logic wr,
                             output logic [31:0] pa, output logic [3:0] cc, output logic f);
    longint lim = (longint'(d >> 20) + 1) * 256;
    longint off = longint'(va & 32'hFFFF);
    if ((d & 32'h10) == 0 || off >= lim) begin
      pa = 0; cc = 8; f = 1;
    end else begin
      pa = (d & 32'h000FFF00) + 32'(off);
      cc = ((d & 32'h60) != 0) ? 4'd2 : 4'd0;
      f  = (cc == 4'd2) && wr;
    end
  endtask

  task automatic compare(input string tag);
    n_tests++;
    if (valid_o !== e_valid || paddr_o !== e_paddr || cc_o !== e_cc || fault_o !== e_fault) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b paddr=%h cc=%0d fault=%0b, expected valid=%0b paddr=%h cc=%0d fault=%0b",
               tag, valid_o, paddr_o, cc_o, fault_o, e_valid, e_paddr, e_cc, e_fault);
    end
  endtask

  // one clock: optional descriptor write and optional request, then compare
  task automatic step(input logic we, input logic [3:0] idx, input logic [31:0] wd,
                      input logic rq, input logic wr, input logic [31:0] va, input string tag);
    logic [31:0] pa; logic [3:0] cc; logic f;
    @(negedge clk_i);
    desc_we_i = we; desc_idx_i = idx; desc_wdata_i = wd;
    req_i = rq; req_write_i = wr; vaddr_i = va;
    model_xlate(m_desc[va[19:16]], va, wr, pa, cc, f); // old descriptor (R10)
    @(posedge clk_i);
    if (we) m_desc[idx] = wd;
    e_valid = rq;
    if (rq) begin e_paddr = pa; e_cc = cc; e_fault = f; end
    #1 compare(tag);
  endtask

  task automatic wr_desc(input logic [3:0] idx, input logic [31:0] wd, input string tag);
    step(1'b1, idx, wd, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic xl(input logic wr, input logic [31:0] va, input string tag);
    step(1'b0, '0, '0, 1'b1, wr, va, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_desc[i] = '0;
    #11;
    n_tests++;
    if (valid_o !== 0 || paddr_o !== 0 || cc_o !== 0 || fault_o !== 0) begin
      n_fail++;
      $display("FAIL R9: reset outputs valid=%0b paddr=%h cc=%0d fault=%0b, expected all 0",
               valid_o, paddr_o, cc_o, fault_o);
    end
    rst_ni = 1'b1;
    xl(1'b0, 32'h0003_0010, "R9 absent after reset");
    xl(1'b0, 32'h000F_0000, "R9 absent after reset");

    // R10: write and translate same edge uses old value
    step(1'b1, 4'd0, 32'h0FF0_0010, 1'b1, 1'b0, 32'h0000_1234, "R10 same-edge old value");
    xl(1'b0, 32'h0000_1234, "R10 new value next cycle");
    xl(1'b1, 32'h0000_FFFF, "R5 writable top of full segment");

    // R3 length limit: L=3 -> 1024 bytes, origin 0x23400
    wr_desc(4'd2, 32'h0032_3410, "R3 load");
    xl(1'b0, 32'h0002_03FF, "R3 last legal byte");
    xl(1'b0, 32'h0002_0400, "R3 first illegal byte");
    xl(1'b1, 32'hABC2_03FF, "R1 upper bits ignored");
    xl(1'b0, 32'hFFF2_0400, "R1 upper bits ignored illegal");

    // R4/R7 protection
    wr_desc(4'd5, 32'h0FF5_0070, "R4 load");
    xl(1'b0, 32'h0005_0100, "R7 read protected no fault");
    xl(1'b1, 32'h0005_0100, "R7 write protected faults");
    wr_desc(4'd5, 32'h0FF5_0030, "R4 bit5 load");
    xl(1'b1, 32'h0005_0008, "R4 bit5 protects");
    wr_desc(4'd5, 32'h0FF5_0050, "R4 bit6 load");
    xl(1'b0, 32'h0005_0008, "R4 bit6 protects");

    // R2/R6 absent with protect bits
    wr_desc(4'd7, 32'h0FF7_FF60, "R2 load");
    xl(1'b0, 32'h0007_0000, "R2 absent illegal read");
    xl(1'b1, 32'h0007_0000, "R6 absent illegal write");
    wr_desc(4'd8, 32'h0008_0070, "R6 load");
    xl(1'b0, 32'h0008_0100, "R6 protected and out of range -> 8 only");
    xl(1'b0, 32'h0008_00FF, "R4 protected in range");

    // R8 idle hold and back-to-back
    step(1'b0, '0, '0, 1'b0, 1'b1, 32'h0000_0004, "R8 idle hold");
    step(1'b0, '0, '0, 1'b0, 1'b0, 32'h0007_0000, "R8 idle hold");
    xl(1'b0, 32'h0000_0044, "R8 back-to-back 1");
    xl(1'b1, 32'h0005_0044, "R8 back-to-back 2");

    // sweep all descriptors with pseudo-random contents
    begin
      logic [31:0] lf = 32'hACE1_2345;
      for (int i = 0; i < 16; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        wr_desc(4'(i), (lf & 32'hFFFF_FF70) | ((i % 4 != 3) ? 32'h10 : 32'h0), "R2 sweep load");
      end
      for (int k = 0; k < 200; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[3]) step(1'b0, '0, '0, 1'b0, 1'b0, '0, "R8 sweep idle");
        else       xl(lf[7], lf, "R5 sweep translate");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, got no finish, expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule